// File: doc/BRIEF.md
# Transmit-Only Serial Memory Streamer

This block reads a byte-wide memory from the bottom address to the top, over and over, and sends the contents out of one open-drain data line. A separate output clock, which is not related to the system clock, sets the bit rate. No host command or address is needed. After reset, and each time the enable returns high, the block leaves the line released for a fixed number of output-clock rising edges. It then starts framing the memory contents.

Each frame takes nine output-clock rising edges: eight data bits, most significant first, then one filler bit that is always a 1 and so leaves the line released. The read address steps by one per frame and wraps from the top address to zero. The output clock is brought into the system clock domain through a two-flop synchronizer, and the block acts on its detected rising edges. A mode controller drives the enable. When the enable is low, the line is released at once and all frame state is held cleared.

Top module: `serial_rom_streamer`

## Requirements
- R1: After reset, with no output-clock edge yet, the data line is released (`sda_pull_low` = 0) and `mem_addr` is 0. No command is needed to start streaming.
- R2: For the first 9 synchronized rising edges of `vclk_in` after reset or after the enable goes high, the line stays released.
- R3: From the 10th rising edge on, each frame drives the byte at the current address, bit 7 first and bit 0 last, one bit per rising edge. A 0 bit sets `sda_pull_low` = 1 and a 1 bit sets `sda_pull_low` = 0. The first frame uses address 0.
- R4: The 9th edge of every frame puts out a filler bit that always leaves the line released, so each frame is 9 edges long.
- R5: `mem_addr` holds the frame's address during its data bits and steps by one on the edge that starts the filler bit. The next frame's byte is read from that address.
- R6: After the frame from address 2^ADDR_W-1 (127 by default), the next frame comes from address 0.
- R7: While `stream_en` is low, the line is released in the same cycle, `mem_addr` clears to 0 on the next clock, and rising edges of `vclk_in` have no effect. Re-enabling restarts the 9-edge idle window and then streams from address 0.
- R8: A rising edge of `vclk_in` changes the line on the 3rd rising edge of `clk` after the new level is present. Between edges, the line and `mem_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stream_en | input | 1 | Enable from the mode controller; low releases the line and clears state |
| vclk_in | input | 1 | Output clock, asynchronous to `clk`, must be low at reset |
| mem_addr | output | ADDR_W | Read address to the byte memory |
| mem_rdata | input | DATA_W | Read data, valid in the same cycle as `mem_addr` |
| sda_pull_low | output | 1 | 1 pulls the open-drain data line low, 0 releases it |

## Verification
An output-clock rising edge reaches the line on the third system clock edge after it appears: two edges pass through the synchronizer and one more updates the frame registers. The bench confirms this once by sampling on the falling clock edges just before and just after that third edge. Every other bit is sampled six system clocks after its output-clock rising edge, while the output clock is still high and well before the next edge, so any latency up to five cycles gives the same result. A drop of the enable must release the line in the same cycle, so the line is checked one time step after the enable changes. The cleared address is checked after the next clock edge.

// File: rtl/streamer_pkg.sv
// Shared types for the transmit-only serial memory streamer.
package streamer_pkg;

    // Sequencer phase: idle window before the first frame, or framing.
    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_STREAM = 1'b1
    } phase_t;

endpackage

// File: rtl/vclk_sync.sv
// vclk_sync: brings the asynchronous output clock into the system clock
// domain with a two-flop synchronizer and flags each rising edge with a
// one-cycle pulse. Assumes the output clock's high and low times each last
// at least two system clock periods, and that it is low during reset.
module vclk_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic vclk_async,
    output logic rise
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Synchronizer chain plus the delayed copy used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= vclk_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Rising edge seen on the synchronized level.
    assign rise = sync_q & ~prev_q;

endmodule

// File: rtl/frame_seq.sv
// frame_seq: counts output-clock edges through the idle window, then
// sequences 9-edge frames (DATA_W data bits plus one filler) and steps the
// memory address once per frame. Assumes WARMUP >= 1. A low enable clears
// all state on the next clock.
module frame_seq #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int WARMUP = 9,
    localparam int IDX_W  = $clog2(DATA_W + 1),
    localparam int WCNT_W = $clog2(WARMUP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rise,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              streaming,
    output logic              load,
    output logic              shift
);

    import streamer_pkg::*;

    localparam logic [WCNT_W-1:0] WARM_LAST = WCNT_W'(WARMUP);
    localparam logic [IDX_W-1:0]  FILL_IDX  = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0]  LAST_DATA = IDX_W'(DATA_W - 1);

    phase_t            phase_q;
    logic [WCNT_W-1:0] warm_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              step;

    assign step      = en & rise;
    assign streaming = (phase_q == PH_STREAM);

    // Load a new byte on the first edge after the idle window or after a filler.
    assign load  = step & (((phase_q == PH_IDLE) && (warm_q == WARM_LAST)) ||
                           (streaming && (idx_q == FILL_IDX)));
    // Shift on every other edge inside a frame, the filler included.
    assign shift = step & streaming & (idx_q != FILL_IDX);

    // Phase, idle counter, bit index and address update on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase_q <= PH_IDLE;
            warm_q  <= '0;
            idx_q   <= '0;
            addr_q  <= '0;
        end else if (rise) begin
            case (phase_q)
                PH_IDLE: begin
                    if (warm_q == WARM_LAST) begin
                        phase_q <= PH_STREAM;
                        idx_q   <= '0;
                    end else begin
                        warm_q <= warm_q + 1'b1;
                    end
                end
                default: begin
                    if (idx_q == FILL_IDX) begin
                        idx_q <= '0;
                    end else begin
                        if (idx_q == LAST_DATA) begin
                            addr_q <= addr_q + 1'b1;
                        end
                        idx_q <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign addr    = addr_q;
    assign bit_idx = idx_q;

endmodule

// File: rtl/bit_shifter.sv
// bit_shifter: holds the byte being sent and presents its top bit on the
// open-drain line. It fills with ones as it shifts, so the shift after the
// last data bit puts the filler 1 on the line without a separate path.
// Assumes load and shift never occur in the same cycle.
module bit_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              streaming,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] rdata,
    output logic              pull_low
);

    logic [DATA_W-1:0] sh_q;

    // Capture the byte on load, move toward the top on shift, fill with ones.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sh_q <= '1;
        end else if (load) begin
            sh_q <= rdata;
        end else if (shift) begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b1};
        end
    end

    // Pull the line low only for a 0 bit while framing and enabled.
    assign pull_low = en & streaming & ~sh_q[DATA_W-1];

endmodule

// File: rtl/serial_rom_streamer.sv
// serial_rom_streamer: top of the transmit-only streamer. It synchronizes
// the output clock, sequences frames over the whole address space and
// drives the open-drain line. Assumes the memory answers mem_addr with
// mem_rdata in the same cycle, and that vclk_in is low during reset.
module serial_rom_streamer #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int WARMUP = 9,
    localparam int IDX_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stream_en,
    input  logic              vclk_in,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              sda_pull_low
);

    logic             vclk_rise;
    logic             streaming;
    logic             load;
    logic             shift;
    logic [IDX_W-1:0] bit_idx;

    vclk_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .vclk_async(vclk_in),
        .rise      (vclk_rise)
    );

    frame_seq #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .WARMUP(WARMUP)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (stream_en),
        .rise     (vclk_rise),
        .addr     (mem_addr),
        .bit_idx  (bit_idx),
        .streaming(streaming),
        .load     (load),
        .shift    (shift)
    );

    bit_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (stream_en),
        .streaming(streaming),
        .load     (load),
        .shift    (shift),
        .rdata    (mem_rdata),
        .pull_low (sda_pull_low)
    );

endmodule

// File: rtl/streamer_chk.sv
// streamer_chk: property checks for serial_rom_streamer, attached by bind.
module streamer_chk #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stream_en,
    input logic              vclk_rise,
    input logic              streaming,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              sda_pull_low
);

    localparam logic [IDX_W-1:0] FILL_IDX  = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_W - 1);

    // R7
    en_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_en |-> !sda_pull_low);

    // R7
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_en |=> (mem_addr == '0) && !streaming);

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !streaming |-> !sda_pull_low);

    // R4
    filler_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (streaming && bit_idx == FILL_IDX) |-> !sda_pull_low);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_en && vclk_rise && streaming && bit_idx == LAST_DATA)
        |=> mem_addr == $past(mem_addr) + 1'b1);

    // R8
    hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_en && !vclk_rise) |=> (!stream_en || $stable(sda_pull_low)));

    // R8
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_en && !vclk_rise) |=> $stable(mem_addr));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= FILL_IDX);

endmodule

bind serial_rom_streamer streamer_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stream_en   (stream_en),
    .vclk_rise   (vclk_rise),
    .streaming   (streaming),
    .bit_idx     (bit_idx),
    .mem_addr    (mem_addr),
    .sda_pull_low(sda_pull_low)
);

// File: tb/tb_serial_rom_streamer.sv
// tb_serial_rom_streamer: drives a slow output clock, models the pull-up
// and the memory, and checks the serial stream bit by bit against a pattern
// computed in the bench.
module tb_serial_rom_streamer;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              stream_en = 1'b1;
    logic              vclk_in = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic              sda_pull_low;
    logic              line;
    logic [DATA_W-1:0] mem [DEPTH];

    int  errs = 0;
    int  checks = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    serial_rom_streamer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WARMUP(9)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .stream_en   (stream_en),
        .vclk_in     (vclk_in),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .sda_pull_low(sda_pull_low)
    );

    assign mem_rdata = mem[mem_addr];
    assign line      = sda_pull_low ? 1'b0 : 1'b1;

    function automatic logic exp_bit(int frame, int j);
        logic [DATA_W-1:0] b;
        b = DATA_W'((((frame % DEPTH) * 37) + 5) & 255);
        return (j < DATA_W) ? b[DATA_W-1-j] : 1'b1;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One output-clock period; samples line and address 6 clocks after the rise.
    task automatic vpulse(output logic l, output int a);
        @(negedge clk) vclk_in = 1'b1;
        repeat (6) @(negedge clk);
        l = line;
        a = int'(mem_addr);
        repeat (2) @(negedge clk);
        vclk_in = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // Checks one frame's nine edges against the pattern.
    task automatic run_frame(int k, int first_j);
        logic l;
        int   a;
        for (int j = first_j; j < 9; j++) begin
            vpulse(l, a);
            chk(j == 8 ? "R4 filler" : "R3 data bit", int'(l), int'(exp_bit(k, j)));
            if (j == 8)
                chk(k % DEPTH == DEPTH - 1 ? "R6 wrap addr" : "R5 next addr", a, (k + 1) % DEPTH);
            else
                chk("R5 frame addr", a, k % DEPTH);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic l;
        int   a;
        for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(((i * 37) + 5) & 255);

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // R1: released, address zero, no command needed
        chk("R1 line after reset", int'(line), 1);
        chk("R1 addr after reset", int'(mem_addr), 0);

        // R2: idle window of 9 edges
        for (int e = 0; e < 9; e++) begin
            vpulse(l, a);
            chk("R2 idle released", int'(l), 1);
            chk("R2 idle addr", a, 0);
        end

        // R8: 10th edge reaches the line on the 3rd clock edge after it
        @(negedge clk) vclk_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 before 3rd edge", int'(line), 1);
        @(negedge clk);
        chk("R8 at 3rd edge", int'(line), int'(exp_bit(0, 0)));
        repeat (5) @(negedge clk);
        chk("R8 held", int'(line), int'(exp_bit(0, 0)));
        vclk_in = 1'b0;
        repeat (8) @(negedge clk);

        // R3 R4 R5 R6: full pass plus wrap
        run_frame(0, 1);
        for (int k = 1; k < 130; k++) run_frame(k, 0);

        // R7: drop enable while the line is pulled low
        vpulse(l, a);
        chk("R3 frame 130 D7", int'(l), int'(exp_bit(130, 0)));
        chk("R7 line low before drop", int'(line), 0);
        @(negedge clk) stream_en = 1'b0;
        #1;
        chk("R7 released at once", int'(line), 1);
        @(negedge clk);
        chk("R7 addr cleared", int'(mem_addr), 0);
        for (int e = 0; e < 3; e++) begin
            vpulse(l, a);
            chk("R7 edges ignored line", int'(l), 1);
            chk("R7 edges ignored addr", a, 0);
        end
        @(negedge clk) stream_en = 1'b1;
        for (int e = 0; e < 9; e++) begin
            vpulse(l, a);
            chk("R7 R2 idle after re-enable", int'(l), 1);
        end
        run_frame(0, 0);
        run_frame(1, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule